// File: doc/BRIEF.md
# Serial 1101 Pattern Detector (Mealy)

This block watches a single serial data bit that is sampled on every rising clock edge. It flags each arrival of the bit pattern 1101. The flag is a Mealy output: it is a combinational function of the present state and the live input bit. It therefore goes high during the same cycle that the closing 1 of the pattern is on the input, before that bit is clocked in. Matches may overlap, because the closing 1 of one match can also serve as the leading 1 of the next. The stream 1101101 therefore yields two flags.

The four-state machine is held in two D flip-flops. The state code follows a Gray-like order: idle = 00, one-seen = 01, two-ones-seen = 11, one-one-zero-seen = 10. With this assignment the upper next-state bit is `b & (a | x)`, the lower next-state bit is simply `x`, and the flag is `a & ~b & x`. A parameter selects between the reduced equations and a plain transition-table form, and both produce identical behaviour. The reset is synchronous and active-high, and it wins over the data bit on the same edge.

Top module: `seq1101_detector`

## Requirements
- R1: A clock edge with `rst` high puts the state at idle (code 00). In the cycle that follows, `z` stays 0 whatever `x` is.
- R2: Reset takes priority over `x` on the same edge. A partly built pattern is discarded, so a 1 that arrives right after reset cannot complete a match begun before it.
- R3: With `x` = 0 the next state is as follows: idle stays idle, one-seen returns to idle, two-ones-seen moves to one-one-zero-seen (10), and one-one-zero-seen returns to idle.
- R4: With `x` = 1 the next state is as follows: idle moves to one-seen, one-seen moves to two-ones-seen, two-ones-seen holds, and one-one-zero-seen moves to one-seen.
- R5: `z` is 1 only when the present state is one-one-zero-seen (10) and `x` is 1. It is 0 in every other case, and it responds in the same cycle without any register.
- R6: Overlapping matches are reported. The input stream 1101101 raises `z` on the 4th bit and on the 7th bit.
- R7: The low state bit always equals the value of `x` captured at the previous edge that was not a reset edge.
- R8: For any stream, `z` is 1 exactly when the current `x` together with the three preceding bits since the last reset spells 1101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the idle state |
| x | input | 1 | Serial data bit, sampled at each rising edge |
| z | output | 1 | Combinational match flag for the pattern 1101 |

## Verification
A reset edge and a transition out of the two-ones-seen state can be requested in the same cycle. The bench provokes this by driving 1,1 and then asserting `rst` while `x` is 0, which without reset would move the machine to one-one-zero-seen. A following 1 must then give `z` = 0, which shows that reset won. The flag and a fresh state transition also coincide on each match: the bench judges both at once by checking `z` while the closing 1 is applied and then confirming that the next 1,0,1 continues the overlap.

// File: rtl/seq1101_pkg.sv
package seq1101_pkg;

   localparam int unsigned STATE_BITS = 2;

   typedef logic [STATE_BITS-1:0] det_code_t;

   localparam det_code_t CODE_IDLE = 2'b00;
   localparam det_code_t CODE_ONE  = 2'b01;
   localparam det_code_t CODE_11   = 2'b11;
   localparam det_code_t CODE_110  = 2'b10;

   localparam int unsigned NS_REDUCED = 0;
   localparam int unsigned NS_TABLE   = 1;

endpackage

// File: rtl/seq1101_next_state.sv
module seq1101_next_state
   import seq1101_pkg::*;
#(
   parameter int unsigned NS_STYLE = NS_REDUCED
) (
   input  logic [STATE_BITS-1:0] cur_st,
   input  logic                  bit_in,
   output logic [STATE_BITS-1:0] nxt_st
);

   if (NS_STYLE > NS_TABLE) begin : g_bad_style
      $error("seq1101_next_state: NS_STYLE must be 0 or 1");
   end

   if (NS_STYLE == NS_REDUCED) begin : g_reduced
      logic hi_q;
      logic lo_q;
      assign hi_q = cur_st[1];
      assign lo_q = cur_st[0];
      assign nxt_st = {lo_q & (hi_q | bit_in), bit_in};
   end else begin : g_table
      always_comb begin
         unique case (cur_st)
            CODE_IDLE: nxt_st = bit_in ? CODE_ONE : CODE_IDLE;
            CODE_ONE:  nxt_st = bit_in ? CODE_11  : CODE_IDLE;
            CODE_11:   nxt_st = bit_in ? CODE_11  : CODE_110;
            CODE_110:  nxt_st = bit_in ? CODE_ONE : CODE_IDLE;
            default:   nxt_st = CODE_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/seq1101_state_reg.sv
module seq1101_state_reg
   import seq1101_pkg::*;
#(
   parameter det_code_t RESET_CODE = CODE_IDLE
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [STATE_BITS-1:0] d_in,
   output logic [STATE_BITS-1:0] q_out
);

   for (genvar gi = 0; gi < STATE_BITS; gi++) begin : g_ff
      always_ff @(posedge clk) begin
         if (rst) q_out[gi] <= RESET_CODE[gi];
         else     q_out[gi] <= d_in[gi];
      end
   end

endmodule

// File: rtl/seq1101_out_decode.sv
module seq1101_out_decode
   import seq1101_pkg::*;
(
   input  logic [STATE_BITS-1:0] cur_st,
   input  logic                  bit_in,
   output logic                  hit
);

   assign hit = cur_st[1] & ~cur_st[0] & bit_in;

endmodule

// File: rtl/seq1101_detector.sv
module seq1101_detector
   import seq1101_pkg::*;
#(
   parameter int unsigned NS_STYLE = NS_REDUCED
) (
   input  logic clk,
   input  logic rst,
   input  logic x,
   output logic z
);

   if (NS_STYLE > NS_TABLE) begin : g_param_chk
      $error("seq1101_detector: unsupported NS_STYLE");
   end

   logic [STATE_BITS-1:0] state_q;
   logic [STATE_BITS-1:0] state_d;

   seq1101_next_state #(.NS_STYLE(NS_STYLE)) u_ns (
      .cur_st (state_q),
      .bit_in (x),
      .nxt_st (state_d)
   );

   seq1101_state_reg #(.RESET_CODE(CODE_IDLE)) u_sr (
      .clk   (clk),
      .rst   (rst),
      .d_in  (state_d),
      .q_out (state_q)
   );

   seq1101_out_decode u_od (
      .cur_st (state_q),
      .bit_in (x),
      .hit    (z)
   );

endmodule

// File: rtl/seq1101_detector_chk.sv
module seq1101_detector_chk (
   input logic       clk,
   input logic       rst,
   input logic       x,
   input logic       z,
   input logic [1:0] st
);

   logic armed_q;
   always_ff @(posedge clk) begin
      if (rst) armed_q <= 1'b1;
   end

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
      (armed_q && $past(rst)) |-> (st == 2'b00 && !z)); // R1

   AST_RESET_WINS: assert property (@(posedge clk) disable iff (rst)
      (armed_q && $past(rst) && $past(x)) |-> (st != 2'b01)); // R2

   AST_ZERO_FROM_11: assert property (@(posedge clk) disable iff (rst)
      (armed_q && st == 2'b11 && !x) |=> (st == 2'b10)); // R3

   AST_HOLD_11: assert property (@(posedge clk) disable iff (rst)
      (armed_q && st == 2'b11 && x) |=> (st == 2'b11)); // R4

   AST_FLAG_AFTER_110: assert property (@(posedge clk) disable iff (rst)
      (armed_q && !$past(rst) && z) |-> ($past(st) == 2'b11 && !$past(x))); // R5

   AST_LSB_TRACKS_X: assert property (@(posedge clk) disable iff (rst)
      (armed_q && !$past(rst)) |-> (st[0] == $past(x))); // R7

endmodule

bind seq1101_detector seq1101_detector_chk chk_i (
   .clk (clk),
   .rst (rst),
   .x   (x),
   .z   (z),
   .st  (state_q)
);

// File: tb/seq1101_detector_tb_top.sv
module seq1101_detector_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 24;
   // each entry is {x, expected z}; stream 1101101001110101100110 11
   localparam logic [1:0] VEC [NVEC] = '{
      2'b10, 2'b10, 2'b00, 2'b11, 2'b10, 2'b00, 2'b11, 2'b00,
      2'b00, 2'b10, 2'b10, 2'b10, 2'b00, 2'b11, 2'b00, 2'b10,
      2'b10, 2'b00, 2'b00, 2'b10, 2'b10, 2'b00, 2'b11, 2'b10
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic x   = 1'b0;
   logic z;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [2:0] hist = 3'b000;

   always #(CLK_PERIOD/2) clk = ~clk;

   seq1101_detector dut_i (
      .clk (clk),
      .rst (rst),
      .x   (x),
      .z   (z)
   );

   task automatic check_z(input logic exp, input string tag);
      checks++;
      if (z !== exp) begin
         errors++;
         $display("FAIL %s: z actual=%b expected=%b", tag, z, exp);
      end
   endtask

   // apply one bit: drive at negedge, check z mid-cycle, model commits at edge
   task automatic drive_bit(input logic v, input logic exp, input string tag);
      @(negedge clk);
      rst = 1'b0;
      x   = v;
      #1;
      check_z(exp, tag);
      hist = {hist[1:0], v};
   endtask

   task automatic do_reset(input logic v);
      @(negedge clk);
      rst = 1'b1;
      x   = v;
      hist = 3'b000;
      @(negedge clk);
      rst = 1'b0;
   endtask

   logic [7:0] lfsr = 8'hA5;

   initial begin
      do_reset(1'b0);
      // R1: immediately after reset a 1 cannot raise z
      #1; x = 1'b1; #1;
      check_z(1'b0, "R1 post-reset");
      rst = 1'b1; @(negedge clk); rst = 1'b0; x = 1'b0; hist = 3'b000;

      // table walk: R3, R4, R5 transitions, R6 overlap (1101101)
      for (int i = 0; i < NVEC; i++) begin
         drive_bit(VEC[i][1], VEC[i][0], "R3,R4,R5,R6 vector");
      end

      // R2: reach two-ones-seen, reset with x=0, then a 1 must not match
      do_reset(1'b0);
      drive_bit(1'b1, 1'b0, "R2 prefix");
      drive_bit(1'b1, 1'b0, "R2 prefix");
      @(negedge clk); rst = 1'b1; x = 1'b0; hist = 3'b000;
      @(negedge clk); rst = 1'b0; x = 1'b1; #1;
      check_z(1'b0, "R2 reset beats x");
      hist = 3'b001;
      drive_bit(1'b1, 1'b0, "R2 rebuild");
      drive_bit(1'b0, 1'b0, "R2 rebuild");
      drive_bit(1'b1, 1'b1, "R2 fresh match");

      // R1: reset while one-one-zero-seen, then a 1 must give z=0
      drive_bit(1'b1, 1'b0, "R1 prefix");
      drive_bit(1'b0, 1'b0, "R1 prefix");
      do_reset(1'b1);
      drive_bit(1'b1, 1'b0, "R1 after reset in 110");

      // R5: z is combinational and follows x inside the cycle
      drive_bit(1'b1, 1'b0, "R5 prefix");
      drive_bit(1'b0, 1'b0, "R5 prefix");
      @(negedge clk); x = 1'b0; #1;
      check_z(1'b0, "R5 state 110 x=0");
      x = 1'b1; #1;
      check_z(1'b1, "R5 state 110 x=1 same cycle");
      hist = {hist[1:0], 1'b1};

      // R8, R7: pseudo-random stream against a history model
      do_reset(1'b0);
      for (int n = 0; n < 300; n++) begin
         logic v;
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         v = lfsr[0] | lfsr[3];
         drive_bit(v, (hist == 3'b110) && v, "R8 random");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R8 watchdog: actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule